// File: doc/BRIEF.md
# Fractional Bit-Rate Clock Divider

This block derives a serial bit clock from a fast reference clock. The reference is typically near 66.66 MHz. The divisor is an integer part plus a fraction. Each output period lasts either the integer count of reference cycles or one cycle more. An error accumulator decides which periods are stretched, so the long-term average rate is exact. Single periods may differ by one reference cycle. With a 10-bit integer field, bit rates from roughly 65 kb/s to more than 20 Mb/s can be reached.

Software writes a 34-bit control word with a load strobe. A mode input chooses one of two fraction formulas. The word waits in a shadow register and takes effect at the next period boundary, so a period that is already running is never cut short. There are two outputs. `tick` is a one-cycle pulse at the start of every bit period. `bclk` is a bit clock with roughly 50% duty. Both outputs are registered and are clocked by the reference clock.

Control word layout: `ctl_word[33:24]` is the integer part IP, `ctl_word[23:12]` is the numerator field NF, and `ctl_word[11:0]` is the denominator field DF. The denominator used is DEN = DF+1. When `alt_mode`=0 the numerator used is NUM = NF+1. When `alt_mode`=1 it is NUM = NF.

Top module: `frac_bitclk_gen`

## Requirements
- R1: From reset, `tick` and `bclk` stay low until a control word is loaded. If the block is idle and `load` is high in one cycle, the first `tick` is high two cycles after that cycle.
- R2: Every output period, measured from one `tick` to the next, lasts IP or IP+1 reference cycles.
- R3: With `alt_mode`=0, any DEN consecutive periods after an update together last DEN*IP + NF+1 cycles.
- R4: With `alt_mode`=1, any DEN consecutive periods after an update together last DEN*IP + NF cycles.
- R5: The accumulator starts from 0 and adds NUM at each period start. If the sum reaches DEN, DEN is subtracted and that period lasts IP+1. For example, IP=5, NF=2, DF=6 in mode 0 gives periods 5,5,6,5,6,5,6.
- R6: A word loaded in the middle of a period does not change that period. It applies from the next period start onward.
- R7: When a new word is applied, the accumulator is cleared, so the stretch pattern restarts from its first period.
- R8: An IP value below 2 is treated as 2.
- R9: A NUM value above DEN is treated as DEN, which makes every period IP+1.
- R10: `tick` is high for exactly one reference cycle, at the first cycle of each period.
- R11: `bclk` is high for the first ceil(L/2) cycles of a period of length L and low for the rest of that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 34 | Control word {IP, NF, DF} |
| alt_mode | input | 1 | 0: fraction is (NF+1)/DEN; 1: fraction is NF/DEN |
| load | input | 1 | Captures `ctl_word` and `alt_mode` into the shadow register |
| tick | output | 1 | One-cycle pulse at the start of each bit period |
| bclk | output | 1 | Bit clock, high for the first half of each period |

## Verification
The assertions check four things on every cycle:
- the outputs stay quiet before the first start;
- `tick` never lasts two cycles;
- `bclk` is high whenever `tick` is high;
- the accumulator stays below the active denominator, and the clamped integer and numerator stay within their limits.

Some behaviours can only be shown by the bench's scenarios, because they are sums or orderings spread across many periods:
- the exact period sequence;
- the total length over DEN periods in each mode;
- the delay before a reloaded word takes effect;
- the restart of the stretch pattern after a reload;
- the duty count of `bclk`.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  parameter int unsigned INT_W  = 10;
  parameter int unsigned FRAC_W = 12;
  localparam int unsigned WORD_W = INT_W + 2 * FRAC_W;
  localparam int unsigned LEN_W  = INT_W + 1;
  localparam int unsigned DEN_W  = FRAC_W + 1;
endpackage

// File: rtl/fbd_ctl_shadow.sv
module fbd_ctl_shadow #(
  parameter int unsigned INT_W   = fbd_pkg::INT_W,
  parameter int unsigned FRAC_W  = fbd_pkg::FRAC_W,
  parameter int unsigned MIN_INT = 2,
  localparam int unsigned WORD_W = INT_W + 2 * FRAC_W,
  localparam int unsigned DEN_W  = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              alt_i,
  input  logic              take_i,
  output logic              pending_o,
  output logic [INT_W-1:0]  nxt_int_o,
  output logic [DEN_W-1:0]  nxt_num_o,
  output logic [DEN_W-1:0]  nxt_den_o
);
  logic [WORD_W-1:0] sh_word;
  logic              sh_alt;
  logic              pending_q;
  logic [INT_W-1:0]  act_int;
  logic [DEN_W-1:0]  act_num, act_den;

  logic [INT_W-1:0]  f_int;
  logic [FRAC_W-1:0] f_nf, f_df;
  logic [DEN_W-1:0]  cl_den, raw_num, cl_num;
  logic [INT_W-1:0]  cl_int;

  always_comb begin
    f_int   = sh_word[WORD_W-1 -: INT_W];
    f_nf    = sh_word[2*FRAC_W-1 -: FRAC_W];
    f_df    = sh_word[FRAC_W-1:0];
    cl_den  = {1'b0, f_df} + DEN_W'(1);
    raw_num = sh_alt ? {1'b0, f_nf} : ({1'b0, f_nf} + DEN_W'(1));
    cl_num  = (raw_num > cl_den) ? cl_den : raw_num;                 // R9
    cl_int  = (f_int < INT_W'(MIN_INT)) ? INT_W'(MIN_INT) : f_int;   // R8
  end

  assign pending_o = pending_q;
  assign nxt_int_o = take_i ? cl_int : act_int;
  assign nxt_num_o = take_i ? cl_num : act_num;
  assign nxt_den_o = take_i ? cl_den : act_den;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_word   <= '0;
      sh_alt    <= 1'b0;
      pending_q <= 1'b0;
      act_int   <= INT_W'(MIN_INT);
      act_num   <= '0;
      act_den   <= DEN_W'(1);
    end else begin
      if (load_i) begin
        sh_word <= word_i;
        sh_alt  <= alt_i;
      end
      if (load_i)      pending_q <= 1'b1;
      else if (take_i) pending_q <= 1'b0;
      if (take_i) begin
        act_int <= cl_int;
        act_num <= cl_num;
        act_den <= cl_den;
      end
    end
  end

  assert_take_pending_R6: assert property (@(posedge clk) disable iff (rst)
    take_i |-> pending_q);
  assert_clamped_R8_R9: assert property (@(posedge clk) disable iff (rst)
    take_i |=> (act_int >= INT_W'(MIN_INT)) && (act_num <= act_den));
endmodule

// File: rtl/fbd_frac_accum.sv
module fbd_frac_accum #(
  parameter int unsigned DEN_W = fbd_pkg::DEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             clear_i,
  input  logic [DEN_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             stretch_o
);
  logic [DEN_W-1:0] acc_q, base, nxt_acc;
  logic [DEN_W:0]   sum;

  always_comb begin
    base      = clear_i ? '0 : acc_q;                     // R7
    sum       = {1'b0, base} + {1'b0, num_i};
    stretch_o = (sum >= {1'b0, den_i});                   // R5
    nxt_acc   = stretch_o ? DEN_W'(sum - {1'b0, den_i}) : DEN_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst)         acc_q <= '0;
    else if (step_i) acc_q <= nxt_acc;
  end

  assert_acc_below_den_R5: assert property (@(posedge clk) disable iff (rst)
    !clear_i |-> (acc_q < den_i));
endmodule

// File: rtl/fbd_period_cnt.sv
module fbd_period_cnt #(
  parameter int unsigned LEN_W = fbd_pkg::LEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             boundary_o,
  output logic             tick_o,
  output logic             bclk_o
);
  logic             run_q, tick_q, bclk_q;
  logic [LEN_W-1:0] cnt_q, half_q;

  assign boundary_o = run_q ? (cnt_q == LEN_W'(1)) : pending_i;
  assign tick_o     = tick_q;
  assign bclk_o     = bclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      half_q <= '0;
      tick_q <= 1'b0;
      bclk_q <= 1'b0;
    end else if (boundary_o) begin
      run_q  <= 1'b1;
      cnt_q  <= len_i;
      half_q <= len_i >> 1;
      tick_q <= 1'b1;                                     // R10
      bclk_q <= 1'b1;
    end else if (run_q) begin
      cnt_q  <= cnt_q - LEN_W'(1);
      tick_q <= 1'b0;
      bclk_q <= (cnt_q - LEN_W'(1)) > half_q;             // R11
    end else begin
      tick_q <= 1'b0;
      bclk_q <= 1'b0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (!tick_q && !bclk_q));
  assert_tick_single_R10: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q);
  assert_bclk_at_tick_R11: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> bclk_q);
  assert_cnt_live_R2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));
endmodule

// File: rtl/frac_bitclk_gen.sv
module frac_bitclk_gen #(
  parameter int unsigned INT_W  = fbd_pkg::INT_W,
  parameter int unsigned FRAC_W = fbd_pkg::FRAC_W,
  localparam int unsigned WORD_W = INT_W + 2 * FRAC_W,
  localparam int unsigned LEN_W  = INT_W + 1,
  localparam int unsigned DEN_W  = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic              alt_mode,
  input  logic              load,
  output logic              tick,
  output logic              bclk
);
  logic             pending, boundary, take, stretch;
  logic [INT_W-1:0] nxt_int;
  logic [DEN_W-1:0] nxt_num, nxt_den;
  logic [LEN_W-1:0] period_len;

  assign take       = boundary && pending;
  assign period_len = {1'b0, nxt_int} + LEN_W'(stretch);

  fbd_ctl_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_INT(2)) u_shadow (
    .clk(clk), .rst(rst), .load_i(load), .word_i(ctl_word), .alt_i(alt_mode),
    .take_i(take), .pending_o(pending), .nxt_int_o(nxt_int),
    .nxt_num_o(nxt_num), .nxt_den_o(nxt_den));

  fbd_frac_accum #(.DEN_W(DEN_W)) u_accum (
    .clk(clk), .rst(rst), .step_i(boundary), .clear_i(take),
    .num_i(nxt_num), .den_i(nxt_den), .stretch_o(stretch));

  fbd_period_cnt #(.LEN_W(LEN_W)) u_period (
    .clk(clk), .rst(rst), .pending_i(pending), .len_i(period_len),
    .boundary_o(boundary), .tick_o(tick), .bclk_o(bclk));
endmodule

// File: tb/frac_bitclk_gen_test.sv
module frac_bitclk_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [33:0] ctl_word = '0;
  logic        alt_mode = 1'b0;
  logic        load = 1'b0;
  logic        tick, bclk;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  frac_bitclk_gen uut (.clk(clk), .rst(rst), .ctl_word(ctl_word),
    .alt_mode(alt_mode), .load(load), .tick(tick), .bclk(bclk));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; raises load for one cycle.
  task automatic put_word(input int a, input int b, input int c, input bit alt);
    ctl_word = {a[9:0], b[11:0], c[11:0]};
    alt_mode = alt;
    load = 1'b1;
    @(negedge clk) load = 1'b0;
  endtask

  // From a negedge, counts cycles until tick is seen.
  task automatic next_tick(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!tick && gap < 5000);
    if (!tick) chk(1'b0, "watchdog-tick", gap, 0);
  endtask

  task automatic start_fresh(input int a, input int b, input int c, input bit alt);
    int g;
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    put_word(a, b, c, alt);
    next_tick(g);
  endtask

  // Called at a tick; ends at the first tick of the new word.
  task automatic reconf(input int a, input int b, input int c, input bit alt);
    int g;
    put_word(a, b, c, alt);
    next_tick(g);
  endtask

  task automatic t_reset;
    bit quiet = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick || bclk) quiet = 1'b0;
    end
    chk(quiet, "R1 idle outputs before load", quiet, 1);
  endtask

  task automatic t_start;
    put_word(5, 2, 6, 1'b0);
    @(negedge clk);
    chk(tick == 1'b1, "R1 first tick two cycles after load", tick, 1);
    @(negedge clk);
    chk(tick == 1'b0, "R10 tick lasts one cycle", tick, 0);
  endtask

  // Called right after t_start: we are 1 cycle into period 1.
  task automatic t_sequence;
    int exp[7] = '{5, 5, 6, 5, 6, 5, 6};
    int g, sum = 0;
    next_tick(g);
    chk(g + 1 == exp[0], "R5 period 1", g + 1, exp[0]);
    sum = g + 1;
    for (int i = 1; i < 7; i++) begin
      next_tick(g);
      chk(g == exp[i], "R5 period sequence", g, exp[i]);
      chk(g == 5 || g == 6, "R2 period in {A,A+1}", g, 5);
      sum += g;
    end
    chk(sum == 7 * 5 + 3, "R3 default-mode total", sum, 38);
  endtask

  task automatic t_clear;
    int g;
    start_fresh(5, 2, 6, 1'b0);
    next_tick(g);
    put_word(5, 2, 6, 1'b0);
    next_tick(g);
    next_tick(g);
    chk(g == 5, "R7 first period after reload", g, 5);
    next_tick(g);
    chk(g == 5, "R7 second period after reload", g, 5);
    next_tick(g);
    chk(g == 6, "R7 third period after reload", g, 6);
  endtask

  task automatic t_alt;
    int g, sum = 0;
    bit inrange = 1'b1;
    reconf(4, 1, 3, 1'b1);
    for (int i = 0; i < 4; i++) begin
      next_tick(g);
      sum += g;
      if (g != 4 && g != 5) inrange = 1'b0;
    end
    chk(sum == 17, "R4 alt-mode total", sum, 17);
    chk(inrange, "R2 alt periods in {A,A+1}", inrange, 1);
  endtask

  task automatic t_shadow;
    int g;
    reconf(8, 0, 0, 1'b1);
    put_word(3, 0, 0, 1'b1);
    next_tick(g);
    chk(g + 1 == 8, "R6 current period unaffected", g + 1, 8);
    next_tick(g);
    chk(g == 3, "R6 new word applies next period", g, 3);
  endtask

  task automatic t_clamp_num;
    int g;
    reconf(6, 10, 3, 1'b0);
    for (int i = 0; i < 4; i++) begin
      next_tick(g);
      chk(g == 7, "R9 numerator clamped", g, 7);
    end
  endtask

  task automatic t_duty;
    int hi = 1;
    int g;
    reconf(7, 0, 0, 1'b1);
    chk(bclk == 1'b1, "R11 bclk high at tick", bclk, 1);
    g = 0;
    do begin
      @(negedge clk);
      g++;
      if (!tick && bclk) hi++;
    end while (!tick && g < 100);
    chk(g == 7, "R11 period length", g, 7);
    chk(hi == 4, "R11 bclk high cycles", hi, 4);
  endtask

  task automatic t_clamp_int;
    int g;
    start_fresh(0, 0, 0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      next_tick(g);
      chk(g == 2, "R8 IP=0 clamped to 2", g, 2);
    end
    start_fresh(1, 0, 0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      next_tick(g);
      chk(g == 3, "R8 IP=1 clamped to 2 plus stretch", g, 3);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_start;
    t_sequence;
    t_clear;
    t_alt;
    t_shadow;
    t_clamp_num;
    t_duty;
    t_clamp_int;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule